// File: doc/BRIEF.md
# Four-Level Nested Interrupt Priority Resolver

This block gathers 24 level-sensitive interrupt request flags and decides which one, if any, is presented to the processor. Each flag is qualified by its own enable bit and by one global enable. It is then given one of four priority levels, built from a low bit and a high bit that software programs per source. Among the qualified requests the highest level wins. Within a level the smallest source number wins. The winner's number and its handler address are driven out together with a request strobe.

The block keeps one in-service bit per level. The processor acknowledges a taken request with a single-cycle pulse, and a return-from-handler pulse retires the innermost level. A new request reaches the processor only when its level is strictly above every level still in service. This gives up to four nested handlers. A wake signal, which ignores the global enable, tells the power manager that some enabled source is pending.

Software reaches the enable and priority registers through a simple single-cycle write port. Writing any of these registers, or the power-control address, masks the request strobe for that cycle and the next. This lets a handler change masks without an interrupt slipping in partway through the update.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset all enable bits, priority bits and in-service bits are clear, so `irq_req_o` and `wake_o` stay low whatever the flags.
- R2: `irq_req_o` is high only when some flag has its source enable bit set and the global enable is set. The write address map is as follows. Address b (0..3) holds the source enables of bank b in bits 5:0, where bit i is source 6b+i. Bit 7 of address 0 is the global enable.
- R3: A source's level is 2*high+low. Its low bit sits at address 4+b and its high bit at address 8+b, in the same bit position as its enable. Level 3 is the most urgent. The winner is the qualified source with the highest level, and `irq_level_o` shows that level.
- R4: When several qualified sources share the top level, the lowest source number wins.
- R5: `irq_vec_o` gives the winning source number, and `irq_addr_o` equals VEC_BASE + 8 * source. The default VEC_BASE is 3.
- R6: An `ack_i` pulse while `irq_req_o` is high sets the in-service bit for `irq_level_o`. An `ack_i` pulse while `irq_req_o` is low changes nothing.
- R7: While any level is in service, `irq_req_o` is high only if the winner's level is strictly greater than the highest in-service level.
- R8: A `reti_i` pulse clears only the highest set in-service bit.
- R9: A write to addresses 0..12 forces `irq_req_o` low in the write cycle and in the cycle after it. Address 12 is power control and stores nothing. Writes to addresses 13..15 store nothing and do not hold off requests.
- R10: `wake_o` is high whenever some flag has its source enable set, even with the global enable clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flags_i | input | 24 | Pending request flag per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| ack_i | input | 1 | Processor took the presented request |
| reti_i | input | 1 | Processor returned from a handler |
| irq_req_o | output | 1 | Request strobe to the processor |
| irq_vec_o | output | 5 | Winning source number |
| irq_addr_o | output | 16 | Handler address of the winner |
| irq_level_o | output | 2 | Priority level of the winner |
| wake_o | output | 1 | Release from Stop or Idle |

## Verification
The in-service bits cannot be read directly. They show only through `irq_req_o`: a stale or wrong bit either blocks a request that should pass or lets an equal-level request through. This becomes visible in the first cycle after the `ack_i` or `reti_i` edge, once a flag at a suitable level is raised. A wrong stored enable or priority bit shows in the second cycle after its write, in `irq_vec_o` or `irq_level_o`, as soon as the hold-off has lapsed. A hold-off that is too short or too long shows in the write cycle itself or in the two cycles after it.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
   localparam int unsigned LVL_W   = 2;
   localparam int unsigned NUM_LVL = 1 << LVL_W;
   typedef logic [LVL_W-1:0]   lvl_t;
   typedef logic [NUM_LVL-1:0] lvl_mask_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_nest_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned BANK_W    = 6,
   parameter int unsigned REG_AW    = 4,
   localparam int unsigned NUM_SRC  = NUM_BANKS * BANK_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en_i,
   input  logic [REG_AW-1:0]         wr_addr_i,
   input  logic [7:0]                wr_data_i,
   output logic [NUM_SRC-1:0]        src_en_o,
   output lvl_t [NUM_SRC-1:0]        src_lvl_o,
   output logic                      glob_en_o,
   output logic                      wr_hit_o
);
   localparam int unsigned PL_BASE = NUM_BANKS;
   localparam int unsigned PH_BASE = 2 * NUM_BANKS;
   localparam int unsigned PWR_ADR = 3 * NUM_BANKS;

   if (BANK_W > 7) begin : g_bad_bank_w
      $error("BANK_W must leave bit 7 for the global enable");
   end
   if (PWR_ADR >= (1 << REG_AW)) begin : g_bad_map
      $error("register map does not fit REG_AW");
   end

   logic [NUM_BANKS-1:0][BANK_W-1:0] en_q, pl_q, ph_q;
   logic                             ge_q;

   assign wr_hit_o = wr_en_i && (wr_addr_i <= REG_AW'(PWR_ADR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              ge_q <= 1'b0;
      else if (wr_en_i && wr_addr_i == '0)     ge_q <= wr_data_i[7];
   end
   assign glob_en_o = ge_q;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q[b] <= '0;
            pl_q[b] <= '0;
            ph_q[b] <= '0;
         end else if (wr_en_i) begin
            if (wr_addr_i == REG_AW'(b))           en_q[b] <= wr_data_i[BANK_W-1:0];
            if (wr_addr_i == REG_AW'(PL_BASE + b)) pl_q[b] <= wr_data_i[BANK_W-1:0];
            if (wr_addr_i == REG_AW'(PH_BASE + b)) ph_q[b] <= wr_data_i[BANK_W-1:0];
         end
      end
      for (genvar i = 0; i < BANK_W; i++) begin : g_bit
         assign src_en_o[b*BANK_W+i]  = en_q[b][i];
         assign src_lvl_o[b*BANK_W+i] = {ph_q[b][i], pl_q[b][i]};
      end
   end

   // R2: global enable follows bit 7 of a write to address 0
   p_glob_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_addr_i == '0) |=> (glob_en_o == $past(wr_data_i[7])));
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
   import irq_nest_pkg::*;
#(
   parameter int unsigned NUM_SRC = 24,
   localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] elig_i,
   input  lvl_t [NUM_SRC-1:0] lvl_i,
   output logic               found_o,
   output logic [SRC_W-1:0]   idx_o,
   output lvl_t               lvl_o
);
   // Scan from the top index down; ">=" lets a lower index take a tie (R4).
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      lvl_o   = '0;
      for (int s = NUM_SRC - 1; s >= 0; s--) begin
         if (elig_i[s] && (!found_o || lvl_i[s] >= lvl_o)) begin
            found_o = 1'b1;
            idx_o   = SRC_W'(s);
            lvl_o   = lvl_i[s];
         end
      end
   end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
   import irq_nest_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ack_i,
   input  logic grant_i,
   input  lvl_t lvl_i,
   input  logic reti_i,
   output logic busy_o,
   output lvl_t top_o
);
   lvl_mask_t isr_q, clr_mask, set_mask;

   always_comb begin
      top_o = '0;
      for (int l = 0; l < NUM_LVL; l++)
         if (isr_q[l]) top_o = lvl_t'(l);
   end
   assign busy_o = |isr_q;

   always_comb begin
      clr_mask = '0;
      set_mask = '0;
      if (reti_i && busy_o)   clr_mask[top_o] = 1'b1;
      if (ack_i && grant_i)   set_mask[lvl_i] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= (isr_q & ~clr_mask) | set_mask;
   end

   // R6: an accepted acknowledge marks its level as in service
   p_ack_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && grant_i) |=> isr_q[$past(lvl_i)]);
   // R8: a return alone retires exactly one level
   p_reti_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reti_i && !(ack_i && grant_i) && busy_o) |=>
         ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
   import irq_nest_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned BANK_W    = 6,
   parameter int unsigned REG_AW    = 4,
   parameter int unsigned ADDR_W    = 16,
   parameter logic [15:0] VEC_BASE  = 16'h0003,
   localparam int unsigned NUM_SRC  = NUM_BANKS * BANK_W,
   localparam int unsigned SRC_W    = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [23:0]        flags_i,
   input  logic               wr_en_i,
   input  logic [3:0]         wr_addr_i,
   input  logic [7:0]         wr_data_i,
   input  logic               ack_i,
   input  logic               reti_i,
   output logic               irq_req_o,
   output logic [4:0]         irq_vec_o,
   output logic [15:0]        irq_addr_o,
   output logic [1:0]         irq_level_o,
   output logic               wake_o
);
   if (NUM_SRC != 24 || REG_AW != 4 || ADDR_W != 16) begin : g_bad_ports
      $error("port widths assume 24 sources, 4-bit address, 16-bit vector");
   end

   logic [NUM_SRC-1:0] src_en, elig;
   lvl_t [NUM_SRC-1:0] src_lvl;
   logic               glob_en, wr_hit, hold_q;
   logic               found, busy, allow;
   logic [SRC_W-1:0]   win_idx;
   lvl_t               win_lvl, top_lvl;

   irq_cfg_regs #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .REG_AW(REG_AW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .src_en_o(src_en), .src_lvl_o(src_lvl), .glob_en_o(glob_en), .wr_hit_o(wr_hit));

   assign elig   = flags_i & src_en & {NUM_SRC{glob_en}};
   assign wake_o = |(flags_i & src_en);

   irq_resolver #(.NUM_SRC(NUM_SRC)) u_res (
      .elig_i(elig), .lvl_i(src_lvl),
      .found_o(found), .idx_o(win_idx), .lvl_o(win_lvl));

   irq_inservice u_isr (
      .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .grant_i(irq_req_o),
      .lvl_i(win_lvl), .reti_i(reti_i), .busy_o(busy), .top_o(top_lvl));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= 1'b0;
      else        hold_q <= wr_hit;
   end

   assign allow       = !busy || (win_lvl > top_lvl);
   assign irq_req_o   = found && allow && !hold_q && !wr_hit;
   assign irq_vec_o   = win_idx;
   assign irq_level_o = win_lvl;
   assign irq_addr_o  = VEC_BASE + (ADDR_W'(win_idx) << 3);

   // R9: the cycle after a register write never carries a request
   p_holdoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> !irq_req_o);
   // R2: no request without the global enable
   p_glob_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> glob_en);
   // R10: a request always comes with wake
   p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o |-> wake_o);
   // R7: while nested, only a strictly higher level is presented
   p_preempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req_o && busy) |-> (irq_level_o > top_lvl));
endmodule

// File: tb/tb_irq_nest_ctrl.sv
module tb_irq_nest_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] flags_i = '0;
   logic        wr_en_i = 1'b0;
   logic [3:0]  wr_addr_i = '0;
   logic [7:0]  wr_data_i = '0;
   logic        ack_i = 1'b0;
   logic        reti_i = 1'b0;
   logic        irq_req_o, wake_o;
   logic [4:0]  irq_vec_o;
   logic [15:0] irq_addr_o;
   logic [1:0]  irq_level_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   irq_nest_ctrl dut (
      .clk(clk), .rst_n(rst_n), .flags_i(flags_i),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .ack_i(ack_i), .reti_i(reti_i),
      .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o), .irq_addr_o(irq_addr_o),
      .irq_level_o(irq_level_o), .wake_o(wake_o));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic settle();
      @(negedge clk); #1;
   endtask

   // one write, then wait out the hold-off
   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en_i = 1'b1; wr_addr_i = 4'(a); wr_data_i = 8'(d);
      @(negedge clk);
      wr_en_i = 1'b0;
      settle();
   endtask

   task automatic pulse_ack();
      @(negedge clk); ack_i = 1'b1;
      @(negedge clk); ack_i = 1'b0; #1;
   endtask

   task automatic pulse_reti();
      @(negedge clk); reti_i = 1'b1;
      @(negedge clk); reti_i = 1'b0; #1;
   endtask

   task automatic t_reset();
      flags_i = '1; settle();
      chk("R1 req", irq_req_o, 0);
      chk("R1 wake", wake_o, 0);
      flags_i = '0;
   endtask

   task automatic t_enable();
      flags_i = 24'h000008; settle();
      chk("R2 req no enable", irq_req_o, 0);
      wr(0, 8'h08);
      chk("R10 wake without global", wake_o, 1);
      chk("R2 req without global", irq_req_o, 0);
      wr(0, 8'h88);
      chk("R2 req enabled", irq_req_o, 1);
      chk("R5 vec", irq_vec_o, 3);
      chk("R5 addr", irq_addr_o, 3 + 8 * 3);
      wr(0, 8'h80);
      chk("R2 req source off", irq_req_o, 0);
      chk("R10 wake source off", wake_o, 0);
   endtask

   task automatic t_priority();
      flags_i = 24'h100008;
      wr(0, 8'h88); wr(3, 8'h04);
      chk("R4 tie at level 0", irq_vec_o, 3);
      wr(11, 8'h04);
      chk("R3 higher level wins", irq_vec_o, 20);
      chk("R3 level 2", irq_level_o, 2);
      chk("R5 addr 20", irq_addr_o, 3 + 8 * 20);
      wr(7, 8'h04);
      chk("R3 level 3", irq_level_o, 3);
      wr(8, 8'h08);
      chk("R3 level 3 beats 2", irq_vec_o, 20);
      wr(7, 0); wr(11, 0); wr(8, 0);
      flags_i = '0;
   endtask

   task automatic t_same_level();
      wr(1, 8'h12); wr(2, 8'h02); wr(5, 8'h12); wr(6, 8'h02);
      flags_i = (24'd1 << 7) | (24'd1 << 10) | (24'd1 << 13); settle();
      chk("R4 lowest of three", irq_vec_o, 7);
      chk("R3 shared level 1", irq_level_o, 1);
      flags_i = (24'd1 << 10) | (24'd1 << 13); settle();
      chk("R4 lowest of two", irq_vec_o, 10);
      flags_i = '0;
   endtask

   task automatic t_holdoff();
      flags_i = 24'h000008; settle();
      chk("R9 before write", irq_req_o, 1);
      @(negedge clk); wr_en_i = 1'b1; wr_addr_i = 4'd4; wr_data_i = 8'h00; #1;
      chk("R9 write cycle", irq_req_o, 0);
      @(negedge clk); wr_en_i = 1'b0; #1;
      chk("R9 cycle after", irq_req_o, 0);
      settle();
      chk("R9 released", irq_req_o, 1);
      @(negedge clk); wr_en_i = 1'b1; wr_addr_i = 4'd12; wr_data_i = 8'hFF;
      @(negedge clk); wr_en_i = 1'b0; #1;
      chk("R9 power write holds", irq_req_o, 0);
      @(negedge clk); wr_en_i = 1'b1; wr_addr_i = 4'd14; wr_data_i = 8'hFF; #1;
      chk("R9 unmapped write cycle", irq_req_o, 1);
      @(negedge clk); wr_en_i = 1'b0; #1;
      chk("R9 unmapped no hold", irq_req_o, 1);
      chk("R9 unmapped stores nothing", irq_level_o, 0);
      flags_i = '0;
   endtask

   task automatic t_nest();
      settle();
      pulse_ack();
      flags_i = 24'h000008; settle();
      chk("R6 stray ack ignored", irq_req_o, 1);
      pulse_ack();
      chk("R7 equal level blocked", irq_req_o, 0);
      wr(11, 8'h04);
      flags_i = 24'h100008; settle();
      chk("R7 higher pre-empts", irq_req_o, 1);
      chk("R7 vec 20", irq_vec_o, 20);
      pulse_ack();
      chk("R6 level 2 in service", irq_req_o, 0);
      wr(7, 8'h04);
      chk("R7 level 3 over 2", irq_req_o, 1);
      wr(7, 8'h00);
      chk("R7 level 2 blocked again", irq_req_o, 0);
      pulse_reti();
      chk("R8 top level retired", irq_req_o, 1);
      chk("R8 vec 20", irq_vec_o, 20);
      flags_i = 24'h000008; settle();
      chk("R8 level 0 still held", irq_req_o, 0);
      pulse_reti();
      chk("R8 all retired", irq_req_o, 1);
      chk("R8 vec 3", irq_vec_o, 3);
      flags_i = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_enable();
      t_priority();
      t_same_level();
      t_holdoff();
      t_nest();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule